// File: doc/BRIEF.md
# Key-Unlocked Configuration-Port Watchdog

This block is a hardware watchdog that software reaches through a pair of byte-wide I/O ports on a simple strobe bus. The lower address of the pair is an index port and the next address up is a data port. The watchdog's registers stay hidden until software writes a fixed four-byte unlock key to the index port. Once the block is unlocked, software writes a register index to the index port and then reads or writes that register through the data port. A dedicated exit write locks the block again.

The watchdog counts down from a programmed 8-bit count, one step per second. A control bit can make each step last sixty seconds instead, which covers timeouts up to 15300 seconds. When the count falls to zero while the reset-enable bit is set, the block drives a reset pulse of fixed length. The count then stays at zero. Software keeps the system alive by rewriting the count before it expires, and each rewrite restarts the full timeout.

Top module: `cfgport_wdt`

## Requirements
- R1: With the base at 0x2E, writing 0x87, 0x01, 0x55, 0x55 in that order to the index port (the base address) unlocks the block. After that, registers are reached through the data port (base plus one).
- R2: With the base at 0x4E, the final key byte is 0xAA. The sequence ending in 0x55 leaves that instance locked.
- R3: A key byte that differs from the expected next byte returns the detector to its start. If that byte is 0x87, it counts as the first byte of a new attempt.
- R4: While the block is locked, data-port writes change no register, and reads of either port return 0xFF. Read data appears on the cycle after the read strobe.
- R5: Index 0x71 is the control register and reads back what was written. Bit 6 enables the reset on timeout and bit 7 selects minutes mode. An index with no register reads as 0x00.
- R6: Writing 0x02 to the index port and then 0x02 to the data port locks the block again, after which data-port reads return 0xFF.
- R7: A data write at index 0x73 loads the countdown. A read of index 0x73 returns the live remaining count. With a count of N and reset enabled, the reset output rises exactly N*CLK_PER_SEC clock edges after the loading edge.
- R8: With control bit 7 set, each count step lasts 60*CLK_PER_SEC cycles.
- R9: At expiry with bit 6 set, the reset output is high for exactly RST_PULSE_CYC cycles. At expiry with bit 6 clear, no pulse occurs. In both cases the count stays at zero.
- R10: Rewriting the count before expiry restarts the full timeout from the rewrite.
- R11: A count of zero performs no countdown and produces no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Bus address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid the cycle after io_rd |
| wdt_reset | output | 1 | Active-high system reset pulse on timeout |

## Verification
The key detector is driven with the correct sequence, a sequence with a wrong last byte, and sequences in which a stray 0x87 restarts the attempt. These separate a detector that merely clears on a mismatch from one that also restarts. A second instance at the alternate base checks that each base takes only its own final byte. The countdown runs in several cases: seconds mode and minutes mode, reset enabled and disabled, a zero count, and a refresh in the middle of a count. Measuring the exact edge at which the reset rises, and how long it stays high, tells apart an off-by-one prescaler, a reload that keeps the old phase, and a wrong pulse length.

// File: rtl/cfgwdt_pkg.sv
package cfgwdt_pkg;
   localparam logic [7:0] KEY_B0      = 8'h87;
   localparam logic [7:0] KEY_B1      = 8'h01;
   localparam logic [7:0] KEY_B2      = 8'h55;
   localparam logic [7:0] KEY_LAST_P  = 8'h55;
   localparam logic [7:0] KEY_LAST_A  = 8'hAA;
   localparam logic [7:0] IDX_CTRL    = 8'h71;
   localparam logic [7:0] IDX_COUNT   = 8'h73;
   localparam logic [7:0] IDX_LEAVE   = 8'h02;
   localparam logic [7:0] LEAVE_VAL   = 8'h02;
   localparam int         CTRL_EN_BIT = 6;
   localparam int         CTRL_MIN_BIT = 7;
   localparam int         SEC_PER_MIN = 60;

   typedef enum logic [2:0] {
      KS_IDLE, KS_GOT1, KS_GOT2, KS_GOT3, KS_OPEN
   } key_state_e;
endpackage

// File: rtl/cfgwdt_keydet.sv
module cfgwdt_keydet
   import cfgwdt_pkg::*;
#(
   parameter logic [7:0] KEY_LAST = 8'h55
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr_i,
   input  logic [7:0] wdata_i,
   input  logic       leave_i,
   output logic       unlocked_o
);
   key_state_e state_q, state_d;
   logic [7:0] want;

   always_comb begin
      case (state_q)
         KS_IDLE: want = KEY_B0;
         KS_GOT1: want = KEY_B1;
         KS_GOT2: want = KEY_B2;
         default: want = KEY_LAST;
      endcase
   end

   always_comb begin
      state_d = state_q;
      if (state_q == KS_OPEN) begin
         if (leave_i) state_d = KS_IDLE;
      end else if (idx_wr_i) begin
         if (wdata_i == want) begin
            case (state_q)
               KS_IDLE: state_d = KS_GOT1;
               KS_GOT1: state_d = KS_GOT2;
               KS_GOT2: state_d = KS_GOT3;
               default: state_d = KS_OPEN;
            endcase
         end else if (wdata_i == KEY_B0) begin
            state_d = KS_GOT1;
         end else begin
            state_d = KS_IDLE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= KS_IDLE;
      else        state_q <= state_d;
   end

   assign unlocked_o = (state_q == KS_OPEN);

   AST_LEAVE_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      leave_i |=> !unlocked_o); // R6
   AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked_o) |-> $past(idx_wr_i && wdata_i == KEY_LAST)); // R1
endmodule

// File: rtl/cfgwdt_regs.sv
module cfgwdt_regs
   import cfgwdt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             unlocked_i,
   input  logic             idx_wr_i,
   input  logic             dat_wr_i,
   input  logic             idx_rd_i,
   input  logic             dat_rd_i,
   input  logic [7:0]       wdata_i,
   input  logic [CNT_W-1:0] remain_i,
   output logic             leave_o,
   output logic             load_o,
   output logic [CNT_W-1:0] load_val_o,
   output logic             enable_o,
   output logic             minutes_o,
   output logic [7:0]       rdata_o
);
   logic [7:0] index_q, ctrl_q, rdata_q, reg_view;
   logic       dat_wr_ok;

   assign dat_wr_ok  = unlocked_i && dat_wr_i;
   assign leave_o    = dat_wr_ok && index_q == IDX_LEAVE && wdata_i == LEAVE_VAL;
   assign load_o     = dat_wr_ok && index_q == IDX_COUNT;
   assign load_val_o = CNT_W'(wdata_i);
   assign enable_o   = ctrl_q[CTRL_EN_BIT];
   assign minutes_o  = ctrl_q[CTRL_MIN_BIT];
   assign rdata_o    = rdata_q;

   always_comb begin
      case (index_q)
         IDX_CTRL:  reg_view = ctrl_q;
         IDX_COUNT: reg_view = 8'(remain_i);
         default:   reg_view = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q <= '0;
         ctrl_q  <= '0;
         rdata_q <= 8'hFF;
      end else begin
         if (!unlocked_i)   index_q <= '0;
         else if (idx_wr_i) index_q <= wdata_i;
         if (dat_wr_ok && index_q == IDX_CTRL) ctrl_q <= wdata_i;
         if (idx_rd_i)      rdata_q <= unlocked_i ? index_q : 8'hFF;
         else if (dat_rd_i) rdata_q <= unlocked_i ? reg_view : 8'hFF;
      end
   end

   AST_LOCKED_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked_i && dat_wr_i) |=> $stable(ctrl_q)); // R4
endmodule

// File: rtl/cfgwdt_timer.sv
module cfgwdt_timer
   import cfgwdt_pkg::*;
#(
   parameter int CNT_W         = 8,
   parameter int CLK_PER_SEC   = 250_000_000,
   parameter int RST_PULSE_CYC = 16,
   parameter bit MIN_MODE_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             enable_i,
   input  logic             minutes_i,
   output logic [CNT_W-1:0] remain_o,
   output logic             wdt_rst_o
);
   localparam int PW  = $clog2(CLK_PER_SEC);
   localparam int PCW = $clog2(RST_PULSE_CYC + 1);

   logic [PW-1:0]    pre_q;
   logic [CNT_W-1:0] remain_q;
   logic [PCW-1:0]   pcnt_q;
   logic             rst_q, sec_tick, step, expire;

   assign sec_tick = (pre_q == PW'(CLK_PER_SEC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || load_i || sec_tick) pre_q <= '0;
      else                             pre_q <= pre_q + 1'b1;
   end

   generate
      if (MIN_MODE_EN) begin : g_minutes
         logic [5:0] min_q;
         always_ff @(posedge clk) begin
            if (!rst_n || load_i) min_q <= '0;
            else if (sec_tick)    min_q <= (min_q == 6'(SEC_PER_MIN - 1)) ? '0 : min_q + 1'b1;
         end
         assign step = sec_tick && (!minutes_i || min_q == 6'(SEC_PER_MIN - 1));
      end else begin : g_seconds
         logic unused_minutes;
         assign unused_minutes = minutes_i;
         assign step = sec_tick;
      end
   endgenerate

   assign expire = step && !load_i && remain_q == CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)                       remain_q <= '0;
      else if (load_i)                  remain_q <= load_val_i;
      else if (step && remain_q != '0)  remain_q <= remain_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_q  <= 1'b0;
         pcnt_q <= '0;
      end else if (expire && enable_i) begin
         rst_q  <= 1'b1;
         pcnt_q <= PCW'(RST_PULSE_CYC - 1);
      end else if (rst_q) begin
         if (pcnt_q == '0) rst_q <= 1'b0;
         else              pcnt_q <= pcnt_q - 1'b1;
      end
   end

   assign remain_o  = remain_q;
   assign wdt_rst_o = rst_q;

   AST_RESET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_q) |-> $past(enable_i)); // R9
   AST_NO_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (remain_q > $past(remain_q)) |-> $past(load_i)); // R7
   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (remain_q == '0 && !load_i) |=> remain_q == '0); // R11
endmodule

// File: rtl/cfgport_wdt.sv
module cfgport_wdt
   import cfgwdt_pkg::*;
#(
   parameter int          ADDR_W        = 8,
   parameter int unsigned BASE_ADDR     = 'h2E,
   parameter int          CLK_PER_SEC   = 250_000_000,
   parameter int          RST_PULSE_CYC = 16,
   parameter bit          MIN_MODE_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic              wdt_reset
);
   localparam int         CNT_W    = 8;
   localparam logic [7:0] KEY_LAST = (BASE_ADDR == 'h4E) ? KEY_LAST_A : KEY_LAST_P;

   generate
      if (BASE_ADDR != 'h2E && BASE_ADDR != 'h4E) begin : g_bad_base
         $error("BASE_ADDR must be 0x2E or 0x4E");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W too small for the base address");
      end
      if (CLK_PER_SEC < 2 || RST_PULSE_CYC < 1) begin : g_bad_timing
         $error("CLK_PER_SEC must be >= 2 and RST_PULSE_CYC >= 1");
      end
   endgenerate

   logic hit_idx, hit_dat, unlocked, leave, load, enable, minutes;
   logic [CNT_W-1:0] load_val, remain;

   assign hit_idx = (io_addr == ADDR_W'(BASE_ADDR));
   assign hit_dat = (io_addr == ADDR_W'(BASE_ADDR + 1));

   cfgwdt_keydet #(.KEY_LAST(KEY_LAST)) keydet_i (
      .clk(clk), .rst_n(rst_n), .idx_wr_i(io_wr && hit_idx),
      .wdata_i(io_wdata), .leave_i(leave), .unlocked_o(unlocked));

   cfgwdt_regs #(.CNT_W(CNT_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .unlocked_i(unlocked),
      .idx_wr_i(io_wr && hit_idx), .dat_wr_i(io_wr && hit_dat),
      .idx_rd_i(io_rd && hit_idx), .dat_rd_i(io_rd && hit_dat),
      .wdata_i(io_wdata), .remain_i(remain), .leave_o(leave), .load_o(load),
      .load_val_o(load_val), .enable_o(enable), .minutes_o(minutes),
      .rdata_o(io_rdata));

   cfgwdt_timer #(.CNT_W(CNT_W), .CLK_PER_SEC(CLK_PER_SEC),
                  .RST_PULSE_CYC(RST_PULSE_CYC), .MIN_MODE_EN(MIN_MODE_EN)) timer_i (
      .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val),
      .enable_i(enable), .minutes_i(minutes), .remain_o(remain),
      .wdt_rst_o(wdt_reset));
endmodule

// File: tb/cfgport_wdt_tb_top.sv
module cfgport_wdt_tb_top;
   localparam int P     = 8;
   localparam int PULSE = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] io_addr = '0;
   logic       io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] rdata_p, rdata_a;
   logic       rst_p, rst_a;
   int         n_chk = 0, n_fail = 0, cyc = 0;

   always #2 clk = ~clk;

   cfgport_wdt #(.BASE_ADDR('h2E), .CLK_PER_SEC(P), .RST_PULSE_CYC(PULSE)) dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(rdata_p), .wdt_reset(rst_p));

   cfgport_wdt #(.BASE_ADDR('h4E), .CLK_PER_SEC(P), .RST_PULSE_CYC(PULSE)) dut_alt (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(rdata_a), .wdt_reset(rst_a));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk); io_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk); io_addr = a; io_rd = 1'b1;
      @(posedge clk); #1;
      d = (a >= 8'h4E) ? rdata_a : rdata_p;
      @(negedge clk); io_rd = 1'b0;
   endtask

   task automatic key(input logic [7:0] a, input logic [7:0] last);
      wr(a, 8'h87); wr(a, 8'h01); wr(a, 8'h55); wr(a, last);
   endtask

   task automatic wreg(input logic [7:0] idx, input logic [7:0] v);
      wr(8'h2E, idx); wr(8'h2F, v);
   endtask

   task automatic rreg(input logic [7:0] idx, output logic [7:0] v);
      wr(8'h2E, idx); rd(8'h2F, v);
   endtask

   // edges after the last write edge until wdt_reset is seen high (0 if never)
   task automatic wait_rise(input int lim, output int k);
      k = 0;
      for (int i = 1; i <= lim; i++) begin
         @(posedge clk); #1;
         if (rst_p) begin k = i; break; end
      end
   endtask

   task automatic pulse_width(output int w);
      w = 1;
      for (int i = 0; i < 100; i++) begin
         @(posedge clk); #1;
         if (!rst_p) break;
         w++;
      end
   endtask

   task automatic t_reset_state;
      logic [7:0] v;
      chk("R9 reset output low after reset", rst_p, 0);
      chk("R4 read data idle value", rdata_p, 8'hFF);
      rd(8'h2F, v); chk("R4 locked data read", v, 8'hFF);
      rd(8'h2E, v); chk("R4 locked index read", v, 8'hFF);
   endtask

   task automatic t_locked_ignore;
      logic [7:0] v; int k;
      wr(8'h2E, 8'h71); wr(8'h2F, 8'h40);
      wr(8'h2E, 8'h73); wr(8'h2F, 8'h02);
      wait_rise(4 * P, k); chk("R4 locked writes start no countdown", k, 0);
      key(8'h2E, 8'h55);
      rreg(8'h71, v); chk("R4 ctrl untouched while locked", v, 8'h00);
      rreg(8'h73, v); chk("R4 count untouched while locked", v, 8'h00);
      wreg(8'h02, 8'h02);
   endtask

   task automatic t_key_variants;
      logic [7:0] v;
      key(8'h2E, 8'h56);
      rd(8'h2F, v); chk("R3 wrong last byte stays locked", v, 8'hFF);
      wr(8'h2E, 8'h87); key(8'h2E, 8'h55);
      rd(8'h2E, v); chk("R3 repeated 0x87 restarts and unlocks", v, 8'h00);
      wreg(8'h02, 8'h02);
      wr(8'h2E, 8'h87); wr(8'h2E, 8'h01); key(8'h2E, 8'h55);
      rd(8'h2E, v); chk("R3 0x87 mid-sequence restarts", v, 8'h00);
      wreg(8'h02, 8'h02);
      wr(8'h2E, 8'h87); wr(8'h2E, 8'h01); wr(8'h2E, 8'h33); wr(8'h2E, 8'h55); wr(8'h2E, 8'h55);
      rd(8'h2F, v); chk("R3 mismatch clears progress", v, 8'hFF);
   endtask

   task automatic t_unlock_rw;
      logic [7:0] v;
      key(8'h2E, 8'h55);
      rd(8'h2E, v); chk("R1 index port readable after key", v, 8'h00);
      wreg(8'h71, 8'hC0);
      rreg(8'h71, v); chk("R5 ctrl readback", v, 8'hC0);
      rreg(8'h20, v); chk("R5 unused index reads zero", v, 8'h00);
      wreg(8'h71, 8'h00);
   endtask

   task automatic t_leave;
      logic [7:0] v;
      wreg(8'h02, 8'h02);
      rd(8'h2F, v); chk("R6 exit relocks data port", v, 8'hFF);
      rd(8'h2E, v); chk("R6 exit relocks index port", v, 8'hFF);
      key(8'h2E, 8'h55);
   endtask

   task automatic t_expire;
      logic [7:0] v; int k, w;
      wreg(8'h71, 8'h40);
      wreg(8'h73, 8'h02);
      rd(8'h2F, v); chk("R7 live count after load", v, 8'h02);
      wreg(8'h73, 8'h03);
      wait_rise(10 * P, k); chk("R7 reset rises N*P edges after load", k, 3 * P);
      pulse_width(w); chk("R9 pulse width", w, PULSE);
      rd(8'h2F, v); chk("R9 count stays zero after expiry", v, 8'h00);
   endtask

   task automatic t_no_enable;
      logic [7:0] v; int k;
      wreg(8'h71, 8'h00);
      wreg(8'h73, 8'h02);
      wait_rise(4 * P, k); chk("R9 no pulse with enable clear", k, 0);
      rd(8'h2F, v); chk("R9 count reached and held zero", v, 8'h00);
   endtask

   task automatic t_zero;
      logic [7:0] v; int k;
      wreg(8'h71, 8'h40);
      wreg(8'h73, 8'h00);
      wait_rise(4 * P, k); chk("R11 zero count no reset", k, 0);
      rd(8'h2F, v); chk("R11 zero count stays zero", v, 8'h00);
   endtask

   task automatic t_refresh;
      int k, w;
      wreg(8'h71, 8'h40);
      wreg(8'h73, 8'h03);
      repeat (2 * P) @(posedge clk);
      wr(8'h2F, 8'h03);
      wait_rise(10 * P, k); chk("R10 refresh restarts full timeout", k, 3 * P);
      pulse_width(w);
   endtask

   task automatic t_minutes;
      int k, w;
      wreg(8'h71, 8'hC0);
      wreg(8'h73, 8'h02);
      wait_rise(200 * P, k); chk("R8 minutes mode step length", k, 2 * 60 * P);
      pulse_width(w); chk("R9 pulse width in minutes mode", w, PULSE);
      wreg(8'h71, 8'h00);
   endtask

   task automatic t_alt_base;
      logic [7:0] v;
      key(8'h4E, 8'h55);
      rd(8'h4F, v); chk("R2 alt base rejects 0x55 ending", v, 8'hFF);
      key(8'h4E, 8'hAA);
      rd(8'h4E, v); chk("R2 alt base unlocks with 0xAA ending", v, 8'h00);
      chk("R2 alt instance no reset", rst_a, 0);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_locked_ignore();
      t_key_variants();
      t_unlock_rw();
      t_leave();
      t_expire();
      t_no_enable();
      t_zero();
      t_refresh();
      t_minutes();
      t_alt_base();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule